// File: doc/BRIEF.md
# Multi-Digit Decimal Up/Down Counter with Parallel Carry Gating

This block counts in decimal across a parameterised number of BCD digits. Each digit is a reversible decade stage, and every stage runs on one shared clock. A single direction input sets up or down counting for the whole chain, and a single active-low enable starts or stops it. No carry or borrow passes from stage to stage. Instead, each stage gets its own enable from an AND of the global enable and the terminal flags of all lower digits. As a result, every digit that has to move does so on the same rising edge.

An active-low asynchronous load sets every digit from its own 4-bit field of a packed data input. The load takes priority over counting. While it is held, the count output shows the data input directly. A chain-wide terminal output goes high when every digit is at its terminal value for the current direction: all nines when counting up, all zeros when counting down. It can serve as an overflow or underflow flag, or as the enable for a further chain.

Top module: `decade_chain_counter`

## Requirements
- R1: While `load_n` is low, `count` equals `load_data`, with or without a clock edge.
- R2: Rising clock edges that occur while `load_n` is low do not count. After `load_n` goes high, counting resumes from the loaded value.
- R3: While `cnt_en_n` is high, no digit changes on a clock edge.
- R4: With `cnt_en_n` low and `count_down` low, each rising edge raises the decimal value of `count` by one.
- R5: With `cnt_en_n` low and `count_down` high, each rising edge lowers the decimal value of `count` by one.
- R6: A digit above the lowest steps only on an edge where every lower digit is at its terminal value (9 when up, 0 when down). All digits that step do so on the same edge, for example 0999 to 1000 in one clock.
- R7: Counting up from all nines gives all zeros in one clock. Counting down from all zeros gives all nines in one clock.
- R8: `chain_term` is high exactly when every digit is 9 and `count_down` is low, or every digit is 0 and `count_down` is high. `cnt_en_n` has no effect on it.
- R9: A digit holding a non-decimal code (10 to 15) becomes 0 on its next up-step or 9 on its next down-step. It does not count as terminal, so it never enables the digit above it.
- R10: Digit i occupies bits [4i+3:4i] of `count` and `load_data`, so the least significant digit sits in the lowest bits. The number of digits is a parameter of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared count clock, rising edge |
| load_n | input | 1 | Asynchronous parallel load, active low |
| cnt_en_n | input | 1 | Global count enable, active low |
| count_down | input | 1 | Direction: 0 counts up, 1 counts down |
| load_data | input | 4*NUM_DIGITS | Preset value, one BCD digit per nibble |
| count | output | 4*NUM_DIGITS | Current count, one BCD digit per nibble |
| chain_term | output | 1 | All digits at terminal value for the current direction |

## Verification
A counting step shows on `count` one edge after the rising clock that takes it. The bench therefore updates its decimal model at the rising edge and compares at the next falling edge, before it changes any input. `chain_term` and the load path are combinational from the digits, `count_down` and `load_data`. Load values are checked a short delay after `load_n` falls, with no clock edge in between. Terminal-flag expectations use the direction value held at the time of the comparison.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;

    typedef logic [3:0] digit_t;

    typedef struct packed {
        digit_t val;
    } stage_state_t;

    localparam digit_t DIGIT_MAX = 4'd9;

    function automatic digit_t digit_up(input digit_t d);
        return (d >= DIGIT_MAX) ? 4'd0 : d + 4'd1;
    endfunction

    function automatic digit_t digit_down(input digit_t d);
        return (d == 4'd0 || d > DIGIT_MAX) ? DIGIT_MAX : d - 4'd1;
    endfunction

endpackage

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
    import bcd_chain_pkg::*;
(
    input  logic   clk,
    input  logic   load_n,
    input  logic   step_en,
    input  logic   count_down,
    input  digit_t preset,
    output digit_t digit,
    output logic   at_term
);

    stage_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            st_d.val = count_down ? digit_down(st_q.val) : digit_up(st_q.val);
        end
    end

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            st_q <= '{val: preset};
        end else begin
            st_q <= st_d;
        end
    end

    // the preset shows through while the load is held
    assign digit   = load_n ? st_q.val : preset;
    assign at_term = count_down ? (digit == 4'd0) : (digit == DIGIT_MAX);

endmodule

// File: rtl/carry_gate_net.sv
module carry_gate_net #(
    parameter int NUM_DIGITS = 4
) (
    input  logic                  glob_en,
    input  logic [NUM_DIGITS-1:0] term,
    output logic [NUM_DIGITS-1:0] stage_en
);

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_gate
        if (i == 0) begin : g_lsd
            assign stage_en[i] = glob_en;
        end else begin : g_upper
            // wide AND of every lower flag: one gate level per stage
            assign stage_en[i] = glob_en & (&term[i-1:0]);
        end
    end

endmodule

// File: rtl/decade_chain_counter.sv
module decade_chain_counter
    import bcd_chain_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    localparam int CW = 4 * NUM_DIGITS
) (
    input  logic          clk,
    input  logic          load_n,
    input  logic          cnt_en_n,
    input  logic          count_down,
    input  logic [CW-1:0] load_data,
    output logic [CW-1:0] count,
    output logic          chain_term
);

    logic [NUM_DIGITS-1:0] term_flags;
    logic [NUM_DIGITS-1:0] stage_en;

    carry_gate_net #(.NUM_DIGITS(NUM_DIGITS)) i_gates (
        .glob_en (!cnt_en_n),
        .term    (term_flags),
        .stage_en(stage_en)
    );

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
        bcd_decade_stage i_stage (
            .clk       (clk),
            .load_n    (load_n),
            .step_en   (stage_en[i]),
            .count_down(count_down),
            .preset    (load_data[4*i +: 4]),
            .digit     (count[4*i +: 4]),
            .at_term   (term_flags[i])
        );
    end

    assign chain_term = &term_flags;

endmodule

// File: rtl/decade_chain_checker.sv
module decade_chain_checker #(
    parameter int NUM_DIGITS = 4,
    localparam int CW = 4 * NUM_DIGITS
) (
    input logic          clk,
    input logic          load_n,
    input logic          cnt_en_n,
    input logic          count_down,
    input logic [CW-1:0] load_data,
    input logic [CW-1:0] count,
    input logic          chain_term
);

    localparam logic [CW-1:0] ALL_NINES = {NUM_DIGITS{4'd9}};

    // R1
    load_shows_data_chk: assert property (@(posedge clk)
        !load_n |-> count == load_data);

    // R3
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!load_n)
        cnt_en_n |=> $stable(count));

    // R4
    lsd_increments_chk: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && !count_down && count[3:0] < 4'd9)
        |=> count[3:0] == $past(count[3:0]) + 4'd1);

    // R6
    upper_waits_for_lsd_chk: assert property (@(posedge clk) disable iff (!load_n)
        (count_down ? count[3:0] != 4'd0 : count[3:0] != 4'd9)
        |=> $stable(count[CW-1:4]));

    // R7
    wrap_up_chk: assert property (@(posedge clk) disable iff (!load_n)
        (chain_term && !cnt_en_n && !count_down) |=> count == '0);

    // R7
    wrap_down_chk: assert property (@(posedge clk) disable iff (!load_n)
        (chain_term && !cnt_en_n && count_down) |=> count == ALL_NINES);

endmodule

bind decade_chain_counter decade_chain_checker #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
    .clk       (clk),
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .count_down(count_down),
    .load_data (load_data),
    .count     (count),
    .chain_term(chain_term)
);

// File: tb/test_decade_chain_counter.sv
module test_decade_chain_counter;

    localparam int N  = 4;
    localparam int CW = 4 * N;
    localparam int M  = 10 ** N;

    logic          clk = 1'b0;
    logic          load_n = 1'b0;
    logic          cnt_en_n = 1'b1;
    logic          count_down = 1'b0;
    logic [CW-1:0] load_data = '0;
    logic [CW-1:0] count;
    logic          chain_term;

    int    n_checks = 0;
    int    n_fail = 0;
    int    model = 0;
    bit    done = 0;
    string tag = "R2";

    always #10ns clk = ~clk;

    decade_chain_counter #(.NUM_DIGITS(N)) i_decade_chain_counter (
        .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .count_down(count_down),
        .load_data(load_data), .count(count), .chain_term(chain_term)
    );

    function automatic int to_int(input logic [CW-1:0] v);
        int r = 0;
        for (int i = N - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [CW-1:0] to_bcd(input int v);
        logic [CW-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic check_vec(input string t, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic check_bit(input string t, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: chain_term=%b expected=%b", t, act, exp);
        end
    endtask

    // one clock; model updated at the rising edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        if (!load_n) model = to_int(load_data);
        else if (!cnt_en_n) model = count_down ? (model + M - 1) % M : (model + 1) % M;
        @(negedge clk);
        check_vec(tag, count, to_bcd(model));
        check_bit("R8", chain_term, count_down ? (model == 0) : (model == M - 1));
    endtask

    // asynchronous load between edges, then release at a falling edge
    task automatic load_value(input logic [CW-1:0] v);
        #5ns;
        load_data = v;
        load_n = 1'b0;
        #1ns;
        check_vec("R1", count, v);
        model = to_int(v);
        @(negedge clk);
        load_n = 1'b1;
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // reset by load of zero; clocks while held must not count (R2)
        load_data = '0;
        cnt_en_n = 1'b0;
        step();
        step();
        @(negedge clk);
        load_n = 1'b1;
        step();

        // R10: nibble order
        load_value({4'd0, 4'd0, 4'd2, 4'd1});
        cnt_en_n = 1'b1;
        step();
        check_vec("R10", count, 16'h0021);

        // R3: hold
        tag = "R3";
        for (int i = 0; i < 20; i++) step();

        // R4 and R6: counting up across 0999 -> 1000
        load_value(to_bcd(0));
        cnt_en_n = 1'b0;
        count_down = 1'b0;
        tag = "R4";
        for (int i = 0; i < 1100; i++) step();
        load_value(to_bcd(999));
        tag = "R6";
        step();
        check_vec("R6", count, 16'h1000);

        // R7: up wrap
        load_value(to_bcd(9995));
        tag = "R7";
        for (int i = 0; i < 10; i++) step();

        // R5 and R7: down wrap and borrow through three digits
        count_down = 1'b1;
        load_value(to_bcd(5));
        tag = "R5";
        for (int i = 0; i < 10; i++) step();
        load_value(to_bcd(1000));
        tag = "R6";
        step();
        check_vec("R6", count, 16'h0999);

        // R8: terminal flag ignores enable
        load_value(to_bcd(0));
        cnt_en_n = 1'b1;
        tag = "R8";
        step();
        check_bit("R8", chain_term, 1'b1);
        count_down = 1'b0;
        #1ns;
        check_bit("R8", chain_term, 1'b0);

        // R2: load asserted across an edge while enabled
        cnt_en_n = 1'b0;
        load_data = to_bcd(4321);
        load_n = 1'b0;
        tag = "R2";
        step();
        step();
        load_n = 1'b1;
        step();

        // R9: non-decimal codes, checked outside the decimal model
        load_value(16'h000C);
        count_down = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_vec("R9", count, 16'h0000);
        load_value(16'h00C9);
        @(posedge clk);
        @(negedge clk);
        check_vec("R9", count, 16'h0000);
        load_value(16'h00C0);
        count_down = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_vec("R9", count, 16'h0099);

        // mixed random traffic
        load_value(to_bcd(5000));
        tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            cnt_en_n = ($urandom_range(0, 7) == 0);
            count_down = ($urandom_range(0, 3) == 0) ? ~count_down : count_down;
            tag = count_down ? "R5" : "R4";
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule